// File: doc/BRIEF.md
# Sequence-Voltage Definite-Time Trip and Reclose Controller

This block is a local protection controller for the two breakers that meet at one bus. It needs no link to any other controller. A fault-type flag says whether the fault is symmetrical or unsymmetrical. For a symmetrical fault the block uses the positive-sequence voltage magnitude. For an unsymmetrical fault it uses the negative-sequence magnitude. From that magnitude it derives a stepped, definite trip delay. When the delay expires while the local fault flag is still present, both breakers open on the same clock edge.

After the trip, the block recloses the two breakers one at a time to find the faulted side. The breaker chosen by the order select closes first. If that breaker sees the fault, it reopens and is locked out, and the other breaker closes later and stays closed. If the first breaker stays healthy, the other breaker closes sooner and is tested in turn. A locked-out breaker stays open until reset. All timing counts a 1 ms tick input. The block acts only while its arm input is high.

Top module: `seqv_trip_reclose`

## Requirements
- R1: After a synchronous reset, both breakers are closed (`close_a`=`close_b`=1) and both lockout flags are 0.
- R2: With `fault_sym`=1, the trip delay in ticks is 20 + 20*floor(`pos_mag`/50), where 1.0 pu is 1500 codes. A lower magnitude therefore gives an earlier trip. The delay counts from the first clock on which `fault_seen` is high while idle and armed.
- R3: With `fault_sym`=0, the trip delay in ticks is 400 - 20*floor(`neg_mag`/100). A higher magnitude therefore gives an earlier trip.
- R4: The trip delay is clamped to the range 20 to 400 ticks on both curves.
- R5: The two breakers open on the same clock edge. That edge is the one carrying the tick that completes the delay.
- R6: If `fault_seen` drops before the delay completes, no breaker opens. The next fault restarts the delay from zero.
- R7: While `arm` is 0, `fault_seen` starts no trip. Dropping `arm` during the delay abandons that delay.
- R8: The first breaker closes on the 10th tick after the trip. It is `close_a` when `order_b_first`=0 and `close_b` when it is 1, with the select sampled at the trip. Both breakers stay open before that tick.
- R9: If `fault_seen` is high while only the first breaker is reclosed, that breaker opens on the next edge and its lockout flag sets. The second breaker then closes on the 30th tick after the trip and stays closed.
- R10: If the first breaker stays healthy, the second breaker closes on the 20th tick after the trip. If `fault_seen` is high within the following 10 ticks, the second breaker opens on the next edge and its lockout flag sets.
- R11: If neither breaker sees the fault during reclosing, the block returns to idle on the 30th tick after the trip, with both breakers closed and unlocked, and a new fault starts a new delay.
- R12: A set lockout flag stays set, and its breaker stays open, until reset. Once a lockout has occurred, `fault_seen` changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| arm | input | 1 | Enables the controller |
| fault_sym | input | 1 | 1 = symmetrical fault, 0 = unsymmetrical |
| pos_mag | input | VW (12) | Positive-sequence magnitude, unsigned, 1500 codes per pu |
| neg_mag | input | VW (12) | Negative-sequence magnitude, unsigned, 1500 codes per pu |
| fault_seen | input | 1 | Local fault-present flag |
| order_b_first | input | 1 | 0 = breaker A recloses first, 1 = breaker B first |
| close_a | output | 1 | Breaker A command, 1 = closed |
| close_b | output | 1 | Breaker B command, 1 = closed |
| lock_a | output | 1 | Breaker A locked out |
| lock_b | output | 1 | Breaker B locked out |

## Verification
The assertions check the following on every cycle:
- a lockout flag never clears outside reset, and a locked breaker is never closed;
- both breakers are open together on the cycle after a trip and stay open until the first reclose;
- the idle state always shows two closed, unlocked breakers;
- a latched delay lies within the clamp range.

Some behaviour only the bench scenarios can show:
- the exact tick counts of each curve step;
- the staggered reclose instants of 10, 20 and 30 ticks;
- which breaker each order select picks;
- that a fault cleared early, or a disarmed block, leaves both breakers closed.

// File: rtl/seqv_pkg.sv
package seqv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TIMING,
    ST_REC,
    ST_T1,
    ST_T1L,
    ST_T2,
    ST_LOCKOUT
  } seqv_state_e;
endpackage

// File: rtl/seqv_delay_curve.sv
module seqv_delay_curve #(
  parameter int unsigned VW        = 12,
  parameter int unsigned DW        = 10,
  parameter int unsigned POS_CODES = 50,
  parameter int unsigned NEG_CODES = 100,
  parameter int unsigned MIN_MS    = 20,
  parameter int unsigned MAX_MS    = 400,
  parameter int unsigned STEP_MS   = 20
) (
  input  logic          sym,
  input  logic [VW-1:0] pos_mag,
  input  logic [VW-1:0] neg_mag,
  output logic [DW-1:0] delay_ms
);
  localparam logic [31:0] MIN32  = 32'(MIN_MS);
  localparam logic [31:0] MAX32  = 32'(MAX_MS);
  localparam logic [31:0] SPAN32 = 32'(MAX_MS - MIN_MS);

  logic [VW-1:0] k_pos, k_neg;
  logic [31:0]   rise, drop, raw;

  always_comb begin
    k_pos = pos_mag / VW'(POS_CODES);
    k_neg = neg_mag / VW'(NEG_CODES);
    rise  = 32'(k_pos) * 32'(STEP_MS);
    drop  = 32'(k_neg) * 32'(STEP_MS);
    if (sym) begin
      raw = (MIN32 + rise > MAX32) ? MAX32 : MIN32 + rise;
    end else begin
      raw = (drop >= SPAN32) ? MIN32 : MAX32 - drop;
    end
    delay_ms = DW'(raw);
  end
endmodule

// File: rtl/seqv_ms_counter.sv
module seqv_ms_counter #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/seqv_breaker_slot.sv
module seqv_breaker_slot (
  input  logic clk,
  input  logic rst,
  input  logic open_req,
  input  logic close_req,
  input  logic lock_req,
  output logic closed,
  output logic locked
);
  always_ff @(posedge clk) begin
    if (rst) begin
      closed <= 1'b1;
      locked <= 1'b0;
    end else if (lock_req) begin
      closed <= 1'b0;
      locked <= 1'b1;
    end else if (open_req) begin
      closed <= 1'b0;
    end else if (close_req && !locked) begin
      closed <= 1'b1;
    end
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked); // R12
  AST_LOCK_OPEN: assert property (@(posedge clk) disable iff (rst)
    locked |-> !closed); // R9
endmodule

// File: rtl/seqv_trip_reclose.sv
module seqv_trip_reclose
  import seqv_pkg::*;
#(
  parameter int unsigned VW          = 12,
  parameter int unsigned DW          = 10,
  parameter int unsigned POS_CODES   = 50,
  parameter int unsigned NEG_CODES   = 100,
  parameter int unsigned MIN_MS      = 20,
  parameter int unsigned MAX_MS      = 400,
  parameter int unsigned STEP_MS     = 20,
  parameter int unsigned FIRST_MS    = 10,
  parameter int unsigned SECOND_OK   = 20,
  parameter int unsigned SECOND_LOCK = 30,
  parameter int unsigned TEST_MS     = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_ms,
  input  logic          arm,
  input  logic          fault_sym,
  input  logic [VW-1:0] pos_mag,
  input  logic [VW-1:0] neg_mag,
  input  logic          fault_seen,
  input  logic          order_b_first,
  output logic          close_a,
  output logic          close_b,
  output logic          lock_a,
  output logic          lock_b
);
  localparam int unsigned NW = DW + 1;
  localparam logic [NW-1:0] T_FIRST = NW'(FIRST_MS);
  localparam logic [NW-1:0] T_OK    = NW'(SECOND_OK);
  localparam logic [NW-1:0] T_LOCK  = NW'(SECOND_LOCK);
  localparam logic [NW-1:0] T_DONE  = NW'(SECOND_OK + TEST_MS);

  seqv_state_e   st_q, st_d;
  logic [DW-1:0] delay_c, delay_q;
  logic [DW-1:0] cnt;
  logic [NW-1:0] nxt;
  logic          cnt_clr, cnt_inc, load_delay;
  logic          first_q;
  logic          fi, si;
  logic [1:0]    open_req, close_req, lock_req, closed, locked;

  seqv_delay_curve #(
    .VW(VW), .DW(DW), .POS_CODES(POS_CODES), .NEG_CODES(NEG_CODES),
    .MIN_MS(MIN_MS), .MAX_MS(MAX_MS), .STEP_MS(STEP_MS)
  ) u_curve (
    .sym(fault_sym), .pos_mag(pos_mag), .neg_mag(neg_mag), .delay_ms(delay_c)
  );

  seqv_ms_counter #(.CW(DW)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
  );

  for (genvar g = 0; g < 2; g++) begin : g_slot
    seqv_breaker_slot u_slot (
      .clk(clk), .rst(rst),
      .open_req(open_req[g]), .close_req(close_req[g]), .lock_req(lock_req[g]),
      .closed(closed[g]), .locked(locked[g])
    );
  end

  assign close_a = closed[0];
  assign close_b = closed[1];
  assign lock_a  = locked[0];
  assign lock_b  = locked[1];

  assign nxt = {1'b0, cnt} + 1'b1;
  assign fi  = first_q;
  assign si  = ~first_q;

  always_comb begin
    st_d       = st_q;
    open_req   = '0;
    close_req  = '0;
    lock_req   = '0;
    cnt_clr    = 1'b0;
    load_delay = 1'b0;
    cnt_inc    = tick_ms && (st_q != ST_IDLE) && (st_q != ST_LOCKOUT);
    case (st_q)
      ST_IDLE: if (arm && fault_seen) begin
        st_d = ST_TIMING; cnt_clr = 1'b1; load_delay = 1'b1;
      end
      ST_TIMING: begin
        if (!arm || !fault_seen) begin
          st_d = ST_IDLE;
        end else if (tick_ms && nxt >= {1'b0, delay_q}) begin
          open_req = 2'b11; st_d = ST_REC; cnt_clr = 1'b1;
        end
      end
      ST_REC: if (tick_ms && nxt == T_FIRST) begin
        close_req[fi] = 1'b1; st_d = ST_T1;
      end
      ST_T1: begin
        if (fault_seen) begin
          lock_req[fi] = 1'b1; open_req[fi] = 1'b1; st_d = ST_T1L;
        end else if (tick_ms && nxt == T_OK) begin
          close_req[si] = 1'b1; st_d = ST_T2;
        end
      end
      ST_T1L: if (tick_ms && nxt == T_LOCK) begin
        close_req[si] = 1'b1; st_d = ST_LOCKOUT;
      end
      ST_T2: begin
        if (fault_seen) begin
          lock_req[si] = 1'b1; open_req[si] = 1'b1; st_d = ST_LOCKOUT;
        end else if (tick_ms && nxt == T_DONE) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = st_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      delay_q <= DW'(MAX_MS);
      first_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load_delay) delay_q <= delay_c;
      if (st_q == ST_TIMING && st_d == ST_REC) first_q <= order_b_first;
    end
  end

  AST_TRIP_PAIR: assert property (@(posedge clk) disable iff (rst)
    ($past(st_q) == ST_TIMING && st_q == ST_REC) |-> (!close_a && !close_b)); // R5
  AST_REC_OPEN: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_REC) |-> (!close_a && !close_b)); // R8
  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> (close_a && close_b && !lock_a && !lock_b)); // R11
  AST_DELAY_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TIMING) |-> (delay_q >= DW'(MIN_MS) && delay_q <= DW'(MAX_MS))); // R4
  AST_DISARMED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !arm) |=> (st_q == ST_IDLE)); // R7
endmodule

// File: tb/seqv_trip_reclose_test.sv
module seqv_trip_reclose_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_ms = 1'b0, arm = 1'b1, fault_sym = 1'b1, fault_seen = 1'b0, order_b_first = 1'b0;
  logic [11:0] pos_mag = '0, neg_mag = '0;
  logic close_a, close_b, lock_a, lock_b;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  seqv_trip_reclose uut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .arm(arm), .fault_sym(fault_sym),
    .pos_mag(pos_mag), .neg_mag(neg_mag), .fault_seen(fault_seen),
    .order_b_first(order_b_first), .close_a(close_a), .close_b(close_b),
    .lock_a(lock_a), .lock_b(lock_b)
  );

  localparam int NV = 11;
  localparam int V_SYM[NV] = '{1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0};
  localparam int V_POS[NV] = '{0, 49, 50, 520, 1500, 0, 0, 0, 0, 0, 0};
  localparam int V_NEG[NV] = '{0, 0, 0, 0, 0, 0, 150, 900, 1900, 2000, 4000};
  localparam int V_EXP[NV] = '{20, 20, 40, 220, 400, 400, 380, 220, 20, 20, 20};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic state4(input string req, input int ca, input int cb,
                        input int la, input int lb);
    check(close_a == ca[0] && close_b == cb[0] && lock_a == la[0] && lock_b == lb[0],
          req, "{close_a,close_b,lock_a,lock_b}",
          {close_a, close_b, lock_a, lock_b}, {ca[0], cb[0], la[0], lb[0]});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    state4("R1 reset", 1, 1, 0, 0);

    // Curve table: R2 symmetrical, R3 unsymmetrical, R4 clamps, R5 pair trip, R11 return
    for (int v = 0; v < NV; v++) begin
      fault_sym = V_SYM[v][0];
      pos_mag = 12'(V_POS[v]);
      neg_mag = 12'(V_NEG[v]);
      fault_seen = 1'b1;
      ticks(V_EXP[v] - 1);
      state4(V_SYM[v] != 0 ? "R2 before delay" : "R3 before delay", 1, 1, 0, 0);
      ticks(1);
      state4("R5 R4 trip at delay", 0, 0, 0, 0);
      fault_seen = 1'b0;
      ticks(30);
      state4("R11 back to idle", 1, 1, 0, 0);
    end

    // R6: fault clears early, then restarts from zero
    fault_sym = 1'b1; pos_mag = '0;
    fault_seen = 1'b1; ticks(19);
    fault_seen = 1'b0; ticks(10);
    state4("R6 cleared fault no trip", 1, 1, 0, 0);
    fault_seen = 1'b1; ticks(19);
    state4("R6 restart not early", 1, 1, 0, 0);
    ticks(1);
    state4("R6 restart trips", 0, 0, 0, 0);
    fault_seen = 1'b0; ticks(30);

    // R7: disarmed ignores faults; dropping arm abandons the delay
    arm = 1'b0; fault_seen = 1'b1; ticks(30);
    state4("R7 disarmed", 1, 1, 0, 0);
    arm = 1'b1; ticks(10);
    arm = 1'b0; ticks(20);
    state4("R7 arm dropped mid delay", 1, 1, 0, 0);
    fault_seen = 1'b0; arm = 1'b1;
    @(negedge clk);

    // R8/R9: A first, A faulted
    order_b_first = 1'b0;
    fault_seen = 1'b1; ticks(20);
    fault_seen = 1'b0;
    ticks(9);
    state4("R8 both open before tick 10", 0, 0, 0, 0);
    ticks(1);
    state4("R8 A recloses at tick 10", 1, 0, 0, 0);
    fault_seen = 1'b1; @(negedge clk);
    state4("R9 A locks out", 0, 0, 1, 0);
    fault_seen = 1'b0;
    ticks(19);
    state4("R9 B still open at tick 29", 0, 0, 1, 0);
    ticks(1);
    state4("R9 B closes at tick 30", 0, 1, 1, 0);
    fault_seen = 1'b1; ticks(50);
    state4("R12 lockout ignores fault", 0, 1, 1, 0);
    fault_seen = 1'b0;
    do_reset();
    state4("R12 R1 reset clears lockout", 1, 1, 0, 0);

    // R8/R10: B first (select latched at trip), B healthy, A faulted
    order_b_first = 1'b1;
    fault_seen = 1'b1; ticks(20);
    fault_seen = 1'b0; order_b_first = 1'b0;
    ticks(10);
    state4("R8 B recloses first", 0, 1, 0, 0);
    ticks(9);
    state4("R10 A open at tick 19", 0, 1, 0, 0);
    ticks(1);
    state4("R10 A closes at tick 20", 1, 1, 0, 0);
    ticks(5);
    fault_seen = 1'b1; @(negedge clk);
    state4("R10 A locks out in test window", 0, 1, 1, 0);
    fault_seen = 1'b0;
    ticks(20);
    state4("R12 lock holds", 0, 1, 1, 0);
    do_reset();
    state4("R1 final reset", 1, 1, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule